// File: doc/BRIEF.md
# Token-Passing Hit Readout Controller

This block reads zero-suppressed pixel hits out of a chain of readout chips that share one output link. Every accepted level-1 trigger opens one readout frame. The controller first sends a header word that carries the trigger number. It then hands a token to chip 0, and the token moves to each following chip in turn. Only the chip that holds the token may give up hit entries. The controller turns each entry into a hit word that carries the chip index, the pixel row, the pixel column and the charge. When the last chip passes the token back, the controller closes the frame with a trailer word.

Each chip feeds the controller through a small FIFO read port. An entry is either a hit or an end marker for the current trigger. A chip that saw no hits has only the end marker, so it gives up the token after one cycle and adds nothing to the stream. Triggers that arrive while a frame is being read wait in a short queue. When the queue is full, a busy flag goes high and any further trigger is dropped.

Top module: `hit_readout_ctrl`

## Requirements
- R1: After reset, and until a trigger is accepted, `out_vld_o`, `busy_o`, `tok_o` and `hit_pop_o` are all zero.
- R2: Every accepted trigger produces exactly one frame. The frame starts with a header word and ends with a trailer word. The header kind is `01` in bits [WORD_W-1:WORD_W-2], the trailer kind is `11`, and both carry the trigger number zero-extended in the low TRIG_W bits. Trigger numbers count accepted triggers from 0 and wrap at 2^TRIG_W.
- R3: Inside a frame the token goes first to chip 0 and then to each following chip in ascending order. At most one chip holds it at any time. `hit_pop_o` is raised only for the token holder, and only when that chip's `hit_vld_i` is high.
- R4: A chip whose first entry for a trigger is the end marker (`hit_eoe_i` high) gives up the token after a single cycle and adds no word. A frame with no hits therefore has its trailer exactly N_CHIP+1 cycles after its header.
- R5: A hit word has kind `10`. Below the kind it holds the chip index (CHIP_W bits), then the row (ROW_W=7, range 0..79), then the column (COL_W=6, range 0..51), then the charge (ADC_W bits, the least significant bits). All fields are copied unchanged from the entry.
- R6: Frames never interleave. Triggers that arrive during a frame are queued, up to TQ_DEPTH of them, and are served in arrival order.
- R7: `busy_o` is high exactly while TQ_DEPTH triggers are waiting. A trigger that arrives in that state is discarded and does not use up a trigger number.
- R8: Each popped hit entry shows up on `out_vld_o`/`out_word_o` one cycle after it is popped, and end markers add no word. With no stalls, a frame with H hits has its trailer N_CHIP+H+1 cycles after its header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Level-1 trigger, one pulse per trigger |
| busy_o | output | 1 | Trigger queue full; new triggers are dropped |
| tok_o | output | N_CHIP | One-hot token: the chip allowed to send |
| hit_vld_i | input | N_CHIP | Per-chip FIFO not empty |
| hit_eoe_i | input | N_CHIP | Per-chip head entry is the end-of-trigger marker |
| hit_row_i | input | N_CHIP*ROW_W | Per-chip head entry row |
| hit_col_i | input | N_CHIP*COL_W | Per-chip head entry column |
| hit_adc_i | input | N_CHIP*ADC_W | Per-chip head entry charge |
| hit_pop_o | output | N_CHIP | Per-chip FIFO read strobe |
| out_vld_o | output | 1 | Output word valid |
| out_word_o | output | 2+CHIP_W+ROW_W+COL_W+ADC_W | Header, hit or trailer word |

## Verification
The bench targets frames in which some or all chips have no hits. A design that stalls on an empty chip, or sends a word for an end marker, gets the header-to-trailer distance wrong. It stops the chain with chips gated and sends triggers until the queue fills, then sends one more. This shows whether busy rises at the right count and whether the extra trigger is dropped without using a trigger number, since a number slip would shift every header that follows. Random traffic with a trigger counter narrowed to six bits makes the number wrap. It also catches token hand-offs that skip a chip, reverse the order, or let a chip without the token pop its FIFO.

// File: rtl/hro_pkg.sv
// Package: word kinds and sequencer states shared by the readout blocks.
package hro_pkg;
    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_HEAD = 2'b01,
        KIND_HIT  = 2'b10,
        KIND_TAIL = 2'b11
    } word_kind_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_READ = 2'b01,
        SEQ_TAIL = 2'b10
    } seq_state_e;
endpackage

// File: rtl/hro_trig_queue.sv
// Trigger queue. It counts accepted triggers that are still waiting for a frame.
// Triggers get consecutive numbers, so a count stands for the whole queue of
// numbers. Assumes pop_i is raised only while pending_o is high.
module hro_trig_queue #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic pop_i,
    output logic pending_o,
    output logic busy_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             push;

    assign full      = (cnt == CNT_W'(DEPTH));
    assign push      = trig_i && !full;
    assign pending_o = (cnt != '0);
    assign busy_o    = full;

    // Occupancy: add accepted triggers, remove the ones a frame starts on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({push, pop_i})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (cnt != '0));
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    assert_drop_keeps_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && trig_i && !pop_i) |=> busy_o);
endmodule

// File: rtl/hro_chip_sel.sv
// Chip selector. It decodes the token pointer into one grant line per chip,
// produces the FIFO read strobe for the holder, and steers the holder's head
// entry to the sequencer. Assumes ptr_i < N_CHIP.
module hro_chip_sel #(
    parameter int N_CHIP = 4,
    parameter int CHIP_W = 2,
    parameter int ROW_W  = 7,
    parameter int COL_W  = 6,
    parameter int ADC_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      grant_en_i,
    input  logic [CHIP_W-1:0]         ptr_i,
    input  logic [N_CHIP-1:0]         hit_vld_i,
    input  logic [N_CHIP-1:0]         hit_eoe_i,
    input  logic [N_CHIP*ROW_W-1:0]   hit_row_i,
    input  logic [N_CHIP*COL_W-1:0]   hit_col_i,
    input  logic [N_CHIP*ADC_W-1:0]   hit_adc_i,
    output logic [N_CHIP-1:0]         tok_o,
    output logic [N_CHIP-1:0]         hit_pop_o,
    output logic                      sel_vld_o,
    output logic                      sel_eoe_o,
    output logic [ROW_W-1:0]          sel_row_o,
    output logic [COL_W-1:0]          sel_col_o,
    output logic [ADC_W-1:0]          sel_adc_o
);
    // One grant line and one read strobe per chip.
    for (genvar g = 0; g < N_CHIP; g++) begin : g_chip
        assign tok_o[g]     = grant_en_i && (ptr_i == CHIP_W'(g));
        assign hit_pop_o[g] = tok_o[g] && hit_vld_i[g];
    end

    assign sel_vld_o = |(tok_o & hit_vld_i);
    assign sel_eoe_o = |(tok_o & hit_eoe_i);

    // Steer the token holder's entry fields to the sequencer.
    always_comb begin
        sel_row_o = '0;
        sel_col_o = '0;
        sel_adc_o = '0;
        for (int c = 0; c < N_CHIP; c++) begin
            if (tok_o[c]) begin
                sel_row_o = hit_row_i[c*ROW_W +: ROW_W];
                sel_col_o = hit_col_i[c*COL_W +: COL_W];
                sel_adc_o = hit_adc_i[c*ADC_W +: ADC_W];
            end
        end
    end

    assert_pop_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_pop_o));
    assert_token_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((tok_o != '0) && !(|(hit_pop_o & hit_eoe_i))) |=> (tok_o == $past(tok_o)));
    assert_token_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(hit_pop_o & hit_eoe_i)) && !tok_o[N_CHIP-1]) |=> (tok_o == ($past(tok_o) << 1)));
endmodule

// File: rtl/hro_frame_seq.sv
// Frame sequencer. It opens a frame when a trigger is waiting, walks the token
// pointer across the chips, and registers the header, hit and trailer words.
// Assumes the selector gives the token holder's entry in the same cycle.
module hro_frame_seq
    import hro_pkg::*;
#(
    parameter int N_CHIP = 4,
    parameter int CHIP_W = 2,
    parameter int ROW_W  = 7,
    parameter int COL_W  = 6,
    parameter int ADC_W  = 8,
    parameter int TRIG_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  pending_i,
    input  logic                                  sel_vld_i,
    input  logic                                  sel_eoe_i,
    input  logic [ROW_W-1:0]                      sel_row_i,
    input  logic [COL_W-1:0]                      sel_col_i,
    input  logic [ADC_W-1:0]                      sel_adc_i,
    output logic                                  q_pop_o,
    output logic                                  grant_en_o,
    output logic [CHIP_W-1:0]                     ptr_o,
    output logic                                  out_vld_o,
    output logic [2+CHIP_W+ROW_W+COL_W+ADC_W-1:0] out_word_o
);
    localparam int WORD_W = 2 + CHIP_W + ROW_W + COL_W + ADC_W;
    localparam int PAY_W  = WORD_W - 2;
    localparam logic [CHIP_W-1:0] LAST = CHIP_W'(N_CHIP - 1);

    seq_state_e        state;
    logic [CHIP_W-1:0] ptr;
    logic [TRIG_W-1:0] trig_num;
    logic [WORD_W-1:0] head_word;
    logic [WORD_W-1:0] hit_word;
    logic [WORD_W-1:0] tail_word;

    assign q_pop_o    = (state == SEQ_IDLE) && pending_i;
    assign grant_en_o = (state == SEQ_READ);
    assign ptr_o      = ptr;
    assign head_word  = {KIND_HEAD, PAY_W'(trig_num)};
    assign tail_word  = {KIND_TAIL, PAY_W'(trig_num)};
    assign hit_word   = {KIND_HIT, ptr, sel_row_i, sel_col_i, sel_adc_i};

    // Frame control and output word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            ptr        <= '0;
            trig_num   <= '0;
            out_vld_o  <= 1'b0;
            out_word_o <= '0;
        end else begin
            out_vld_o <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (pending_i) begin
                        out_vld_o  <= 1'b1;
                        out_word_o <= head_word;
                        ptr        <= '0;
                        state      <= SEQ_READ;
                    end
                end
                SEQ_READ: begin
                    if (sel_vld_i) begin
                        if (sel_eoe_i) begin
                            if (ptr == LAST) begin
                                state <= SEQ_TAIL;
                            end else begin
                                ptr <= ptr + 1'b1;
                            end
                        end else begin
                            out_vld_o  <= 1'b1;
                            out_word_o <= hit_word;
                        end
                    end
                end
                SEQ_TAIL: begin
                    out_vld_o  <= 1'b1;
                    out_word_o <= tail_word;
                    trig_num   <= trig_num + 1'b1;
                    state      <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assert_head_after_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop_o |=> (out_vld_o && (out_word_o[WORD_W-1 -: 2] == KIND_HEAD)));
    assert_hit_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_en_o && sel_vld_i && !sel_eoe_i) |=> (out_vld_o && (out_word_o[WORD_W-1 -: 2] == KIND_HIT)));
    assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);
endmodule

// File: rtl/hit_readout_ctrl.sv
// Top of the token-passing readout controller. It connects the trigger queue,
// the chip selector and the frame sequencer. Assumes each chip FIFO holds, for
// every trigger, its hit entries followed by one end marker.
module hit_readout_ctrl #(
    parameter int N_CHIP   = 4,
    parameter int ROW_W    = 7,
    parameter int COL_W    = 6,
    parameter int ADC_W    = 8,
    parameter int TRIG_W   = 8,
    parameter int TQ_DEPTH = 4,
    parameter int CHIP_W   = $clog2(N_CHIP)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  trig_i,
    output logic                                  busy_o,
    output logic [N_CHIP-1:0]                     tok_o,
    input  logic [N_CHIP-1:0]                     hit_vld_i,
    input  logic [N_CHIP-1:0]                     hit_eoe_i,
    input  logic [N_CHIP*ROW_W-1:0]               hit_row_i,
    input  logic [N_CHIP*COL_W-1:0]               hit_col_i,
    input  logic [N_CHIP*ADC_W-1:0]               hit_adc_i,
    output logic [N_CHIP-1:0]                     hit_pop_o,
    output logic                                  out_vld_o,
    output logic [2+CHIP_W+ROW_W+COL_W+ADC_W-1:0] out_word_o
);
    logic              pending;
    logic              q_pop;
    logic              grant_en;
    logic [CHIP_W-1:0] ptr;
    logic              sel_vld;
    logic              sel_eoe;
    logic [ROW_W-1:0]  sel_row;
    logic [COL_W-1:0]  sel_col;
    logic [ADC_W-1:0]  sel_adc;

    hro_trig_queue #(.DEPTH(TQ_DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .pop_i(q_pop),
        .pending_o(pending), .busy_o(busy_o)
    );

    hro_chip_sel #(
        .N_CHIP(N_CHIP), .CHIP_W(CHIP_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADC_W(ADC_W)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .grant_en_i(grant_en), .ptr_i(ptr),
        .hit_vld_i(hit_vld_i), .hit_eoe_i(hit_eoe_i), .hit_row_i(hit_row_i),
        .hit_col_i(hit_col_i), .hit_adc_i(hit_adc_i), .tok_o(tok_o),
        .hit_pop_o(hit_pop_o), .sel_vld_o(sel_vld), .sel_eoe_o(sel_eoe),
        .sel_row_o(sel_row), .sel_col_o(sel_col), .sel_adc_o(sel_adc)
    );

    hro_frame_seq #(
        .N_CHIP(N_CHIP), .CHIP_W(CHIP_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .ADC_W(ADC_W), .TRIG_W(TRIG_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .pending_i(pending), .sel_vld_i(sel_vld),
        .sel_eoe_i(sel_eoe), .sel_row_i(sel_row), .sel_col_i(sel_col),
        .sel_adc_i(sel_adc), .q_pop_o(q_pop), .grant_en_o(grant_en),
        .ptr_o(ptr), .out_vld_o(out_vld_o), .out_word_o(out_word_o)
    );

    assert_idle_no_token_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_en) |-> (tok_o == '0 && hit_pop_o == '0));
endmodule

// File: tb/tb_hit_readout_ctrl.sv
// Bench: directed corner cases plus seeded random frames, checked against a
// word stream the bench predicts from the requirements.
module tb_hit_readout_ctrl;
    localparam int NC = 4, RW = 7, CW = 6, AW = 8, TW = 6, QD = 4, CHW = 2;
    localparam int WW = 2 + CHW + RW + CW + AW;
    localparam int EW = 1 + RW + CW + AW;
    localparam int XDEP = 4096, FDEP = 512;

    logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0, gate = 1'b0;
    always #2 clk = ~clk;

    logic          busy, out_vld;
    logic [NC-1:0] tok, hit_vld, hit_eoe, hit_pop;
    logic [NC*RW-1:0] hit_row;
    logic [NC*CW-1:0] hit_col;
    logic [NC*AW-1:0] hit_adc;
    logic [WW-1:0] out_word;

    hit_readout_ctrl #(.N_CHIP(NC), .ROW_W(RW), .COL_W(CW), .ADC_W(AW),
                       .TRIG_W(TW), .TQ_DEPTH(QD)) dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .busy_o(busy), .tok_o(tok),
        .hit_vld_i(hit_vld), .hit_eoe_i(hit_eoe), .hit_row_i(hit_row),
        .hit_col_i(hit_col), .hit_adc_i(hit_adc), .hit_pop_o(hit_pop),
        .out_vld_o(out_vld), .out_word_o(out_word)
    );

    // Chip FIFO models
    logic [EW-1:0] cmem [NC][1024];
    logic [9:0]    rdp [NC];
    logic [9:0]    wrp [NC];
    for (genvar g = 0; g < NC; g++) begin : g_fifo
        assign hit_vld[g] = !gate && (rdp[g] != wrp[g]);
        assign {hit_eoe[g], hit_row[g*RW +: RW], hit_col[g*CW +: CW], hit_adc[g*AW +: AW]} = cmem[g][rdp[g]];
    end
    always @(posedge clk) begin
        for (int c = 0; c < NC; c++) begin
            if (!rst_n) rdp[c] <= '0;
            else if (hit_pop[c]) rdp[c] <= rdp[c] + 1'b1;
        end
    end

    logic [WW-1:0] exq [XDEP];
    int egap [FDEP];
    int ewr = 0, erd = 0, fwr = 0, frd = 0, next_num = 0;
    int checks = 0, errors = 0, cyc = 0, hdr_cyc = 0;
    bit done = 1'b0;
    logic [NC-1:0] prev_tok = '0;

    function automatic logic [WW-1:0] mk_ctl(input logic [1:0] kind, input int num);
        return {kind, (WW-2)'(num % (1 << TW))};
    endfunction
    function automatic logic [WW-1:0] mk_hit(input int chip, input int r, input int c, input int a);
        return {2'b10, CHW'(chip), RW'(r), CW'(c), AW'(a)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mode 0 random, 1 no hits, 2 two hits on chip 2 only
    task automatic load_event(input int mode, input bit gap_ok);
        int tot = 0;
        exq[ewr] = mk_ctl(2'b01, next_num); ewr++;
        for (int c = 0; c < NC; c++) begin
            int nh;
            nh = (mode == 0) ? int'($urandom % 3) : ((mode == 2 && c == 2) ? 2 : 0);
            for (int h = 0; h < nh; h++) begin
                int r, cl, a;
                r = $urandom % 80; cl = $urandom % 52; a = $urandom % 256;
                cmem[c][wrp[c]] = {1'b0, RW'(r), CW'(cl), AW'(a)};
                wrp[c] = wrp[c] + 1'b1;
                exq[ewr] = mk_hit(c, r, cl, a); ewr++;
                tot++;
            end
            cmem[c][wrp[c]] = {1'b1, {(EW-1){1'b0}}};
            wrp[c] = wrp[c] + 1'b1;
        end
        exq[ewr] = mk_ctl(2'b11, next_num); ewr++;
        egap[fwr] = gap_ok ? (NC + 1 + tot) : -1;
        fwr++;
        next_num++;
    endtask

    task automatic pulse;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic drain;
        while (erd < ewr && cyc < 150000) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Output and token monitor
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (out_vld) begin
                if (erd >= ewr) begin
                    chk(1'b0, "R6 unexpected word", out_word, '0);
                end else begin
                    chk(out_word == exq[erd], (out_word[WW-1 -: 2] == 2'b10) ? "R5 hit word" : "R2 frame word",
                        out_word, exq[erd]);
                    erd++;
                    if (out_word[WW-1 -: 2] == 2'b01) hdr_cyc = cyc;
                    if (out_word[WW-1 -: 2] == 2'b11) begin
                        if (frd < fwr && egap[frd] >= 0)
                            chk((cyc - hdr_cyc) == egap[frd], (egap[frd] == NC + 1) ? "R4 empty frame length" : "R8 frame length",
                                WW'(cyc - hdr_cyc), WW'(egap[frd]));
                        frd++;
                    end
                end
            end
            if (hit_pop != '0)
                chk(((hit_pop & ~tok) == '0) && $onehot0(tok), "R3 pop outside token", WW'(hit_pop), WW'(tok));
            if (tok != '0 && prev_tok == '0)
                chk(tok == NC'(1), "R3 first holder", WW'(tok), WW'(1));
            else if (tok != '0 && tok != prev_tok)
                chk(tok == (prev_tok << 1), "R3 token order", WW'(tok), WW'(prev_tok << 1));
            prev_tok = tok;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int c = 0; c < NC; c++) wrp[c] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_vld == 1'b0, "R1 reset out_vld", WW'(out_vld), '0);
        chk(busy == 1'b0, "R1 reset busy", WW'(busy), '0);
        chk(tok == '0 && hit_pop == '0, "R1 reset token", WW'(tok), '0);

        // R4: a frame with no hits at all, then one with hits on chip 2 only
        load_event(1, 1'b1); pulse(); drain();
        load_event(2, 1'b1); pulse(); drain();

        // R7: stall the chain, fill the queue, overflow it by one
        gate = 1'b1;
        for (int k = 0; k < QD + 1; k++) load_event(0, 1'b0);
        pulse();
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R7 busy low with queue not full", WW'(busy), '0);
        for (int k = 0; k < QD; k++) pulse();
        chk(busy == 1'b1, "R7 busy when queue full", WW'(busy), WW'(1));
        pulse();
        chk(busy == 1'b1, "R7 busy after dropped trigger", WW'(busy), WW'(1));
        gate = 1'b0;
        drain();
        chk(busy == 1'b0, "R7 busy cleared after drain", WW'(busy), '0);

        // R6 / R2 / R5: random traffic, trigger numbers wrap at 2^TW
        for (int k = 0; k < 200; k++) begin
            load_event(0, 1'b1);
            while (busy) @(negedge clk);
            pulse();
            repeat ($urandom % 16) @(negedge clk);
        end
        drain();
        chk(erd == ewr, "R2 all expected words seen", WW'(erd), WW'(ewr));
        chk(frd == fwr, "R6 frame count", WW'(frd), WW'(fwr));
        chk(busy == 1'b0 && tok == '0, "R1 idle after traffic", WW'(tok), '0);

        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end
endmodule